// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Hardware Address Filtering

This block is the receive half of an asynchronous serial port that supports multi-drop networks. It watches a serial line and finds a start bit using a 16x oversampling enable. It samples eight data bits, least significant first, plus one further bit. It then decides whether to place the result in a one-entry holding buffer and raise a sticky receive flag. The two-bit mode input picks the frame shape. Code 0 is the synchronous shift mode, which this block does not handle, so it receives nothing. Code 1 is the 8-bit frame, where the stop bit value is kept as the ninth bit. Codes 2 and 3 are 9-bit frames, where a real ninth data bit precedes the stop bit.

In the 9-bit modes a multiprocessor enable turns on address filtering. An incoming frame is then only buffered when its ninth bit is 1 and its byte matches the node address. The byte may match in two ways. The first is the "given" form: it agrees with the address register wherever the mask register holds 1. The second is the "broadcast" form: it has a 1 in every position that is 1 in the OR of address and mask. Both match results for the buffered byte are also driven out, so software can tell which kind of address arrived. The baud source is outside the block and arrives as the oversampling enable.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset the receive flag, the buffered byte and the ninth bit are all 0.
- R2: In mode 1 a frame is a low start bit, 8 data bits sent least significant bit first, and a stop bit. The byte is buffered, the stop bit value appears on the ninth-bit output, and the receive flag is set.
- R3: In modes 2 and 3 with filtering off, every frame is buffered. Such a frame is a start bit, 8 data bits sent least significant bit first, a ninth bit and a stop bit, and the ninth bit appears on its output.
- R4: A start bit is abandoned if the line is high again at its middle, which is 8 oversampling ticks after the low level is first seen. Nothing is buffered and the flag stays clear.
- R5: While the receive enable is 0, no new frame starts, so the flag and the buffered byte do not change.
- R6: The receive flag stays set until the clear input is pulsed. A clear pulse takes effect on the next clock. A frame that completes while the flag is set is dropped and the old byte is kept.
- R7: The given-match output is 1 when the buffered byte equals the address in every bit where the mask is 1.
- R8: The broadcast-match output is 1 when the buffered byte has a 1 in every bit where (address OR mask) is 1.
- R9: In modes 2 and 3 with filtering on, a frame is buffered only if its ninth bit is 1 and its byte gives a given or broadcast match. All other frames are discarded.
- R10: In mode 0 no frame is received.
- R11: In mode 1 the multiprocessor enable has no effect, so any frame is buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| tick16_i | input | 1 | Oversampling enable, 16 pulses per bit time |
| mode_i | input | 2 | Frame mode: 0 shift (no receive), 1 8-bit, 2 and 3 9-bit |
| mpe_i | input | 1 | Address filtering enable for the 9-bit modes |
| ren_i | input | 1 | Receive enable |
| addr_i | input | 8 | Node address |
| mask_i | input | 8 | Address mask, 1 means the bit is compared |
| flag_clr_i | input | 1 | One-cycle pulse that clears the receive flag |
| data_o | output | 8 | Buffered received byte |
| bit9_o | output | 1 | Buffered ninth bit, or the stop bit in mode 1 |
| rx_flag_o | output | 1 | Sticky receive flag |
| given_match_o | output | 1 | Buffered byte gives a masked match to the node address |
| bcast_match_o | output | 1 | Buffered byte gives a broadcast match |

## Verification
A sampling counter that slips shows up as a wrongly shifted byte on data_o. This is visible as soon as the flag rises, about half a bit time after the last data bit is sent. A sequencer stuck outside its idle state shows up later, when the next frame never raises the flag. A wrong filter or a wrong lock decision shows up on rx_flag_o and data_o at that same frame end: frames that should be dropped get buffered, frames that should be buffered are lost, or a locked byte is overwritten. Errors in the match logic show up at once on the two match outputs after any load.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   localparam logic [1:0] MODE_SHIFT = 2'd0;
   localparam logic [1:0] MODE_UART8 = 2'd1;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
   import uart_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   input  logic              arm_i,
   input  logic              nine_i,
   output logic [DATA_W:0]   shift_o,
   output logic              done_o
);
   localparam int CNT_W = $clog2(OSR);
   localparam int BITS  = DATA_W + 1;
   localparam int IDX_W = $clog2(BITS + 1);
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS - 1);

   rx_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         idx     <= '0;
         shift_o <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            case (state)
               RX_IDLE: begin
                  if (arm_i && !rxd_i) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == MID_CNT) begin
                     cnt <= '0;
                     idx <= '0;
                     state <= rxd_i ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == LAST_CNT) begin
                     cnt     <= '0;
                     shift_o <= {rxd_i, shift_o[DATA_W:1]};
                     if (idx == LAST_IDX) begin
                        done_o <= 1'b1;
                        state  <= nine_i ? RX_STOP : RX_IDLE;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  if (cnt == LAST_CNT) begin
                     cnt   <= '0;
                     state <= RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_rx_addr_match.sv
module uart_rx_addr_match #(
   parameter int  DATA_W   = 8,
   parameter bit  BCAST_EN = 1'b1
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic [DATA_W-1:0] addr_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              given_o,
   output logic              bcast_o
);
   assign given_o = ((byte_i ^ addr_i) & mask_i) == '0;

   generate
      if (BCAST_EN) begin : g_bcast
         logic [DATA_W-1:0] must_one;
         assign must_one = addr_i | mask_i;
         assign bcast_o  = (byte_i & must_one) == must_one;
      end else begin : g_no_bcast
         assign bcast_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W:0]   frame_i,
   input  logic              accept_i,
   input  logic              clr_i,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o,
   output logic              flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         bit9_o <= 1'b0;
         flag_o <= 1'b0;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end else if (done_i && accept_i && !flag_o) begin
         data_o <= frame_i[DATA_W-1:0];
         bit9_o <= frame_i[DATA_W];
         flag_o <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
   import uart_rx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int OSR      = 16,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd_i,
   input  logic              tick16_i,
   input  logic [1:0]        mode_i,
   input  logic              mpe_i,
   input  logic              ren_i,
   input  logic [DATA_W-1:0] addr_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic              flag_clr_i,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o,
   output logic              rx_flag_o,
   output logic              given_match_o,
   output logic              bcast_match_o
);
   generate
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("OSR must be a power of two of at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W:0] frame_w;
   logic            done_w;
   logic            arm_w;
   logic            rx_given_w;
   logic            rx_bcast_w;
   logic            filter_w;
   logic            accept_w;

   assign arm_w = ren_i && (mode_i != MODE_SHIFT);

   uart_rx_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_sampler (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick16_i),
      .rxd_i   (rxd_i),
      .arm_i   (arm_w),
      .nine_i  (mode_i[1]),
      .shift_o (frame_w),
      .done_o  (done_w)
   );

   uart_rx_addr_match #(.DATA_W(DATA_W), .BCAST_EN(BCAST_EN)) u_rx_match (
      .byte_i  (frame_w[DATA_W-1:0]),
      .addr_i  (addr_i),
      .mask_i  (mask_i),
      .given_o (rx_given_w),
      .bcast_o (rx_bcast_w)
   );

   assign filter_w = mpe_i && mode_i[1];
   assign accept_w = (mode_i != MODE_SHIFT) &&
                     (!filter_w || (frame_w[DATA_W] && (rx_given_w || rx_bcast_w)));

   uart_rx_buffer #(.DATA_W(DATA_W)) u_buffer (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_i   (done_w),
      .frame_i  (frame_w),
      .accept_i (accept_w),
      .clr_i    (flag_clr_i),
      .data_o   (data_o),
      .bit9_o   (bit9_o),
      .flag_o   (rx_flag_o)
   );

   uart_rx_addr_match #(.DATA_W(DATA_W), .BCAST_EN(BCAST_EN)) u_buf_match (
      .byte_i  (data_o),
      .addr_i  (addr_i),
      .mask_i  (mask_i),
      .given_o (given_match_o),
      .bcast_o (bcast_match_o)
   );
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_i,
   input logic              mpe_i,
   input logic              flag_clr_i,
   input logic [DATA_W-1:0] data_o,
   input logic              bit9_o,
   input logic              rx_flag_o,
   input logic              given_match_o,
   input logic              bcast_match_o
);
   // R6: flag holds until cleared
   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag_o && !flag_clr_i) |=> rx_flag_o);

   // R6: buffered byte is locked while the flag is set
   a_r6_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flag_o |=> $stable(data_o));

   // R6: clear pulse takes effect on the next clock
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr_i |=> !rx_flag_o);

   // R9: with filtering on, a load needs ninth bit 1 and an address hit
   a_r9_filter: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_flag_o) && $past(mpe_i) && $past(mode_i[1]))
      |-> (bit9_o && (given_match_o || bcast_match_o)));

   // R10: mode 0 never loads a frame
   a_r10_mode0: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd0) |=> !$rose(rx_flag_o));
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mode_i        (mode_i),
   .mpe_i         (mpe_i),
   .flag_clr_i    (flag_clr_i),
   .data_o        (data_o),
   .bit9_o        (bit9_o),
   .rx_flag_o     (rx_flag_o),
   .given_match_o (given_match_o),
   .bcast_match_o (bcast_match_o)
);

// File: tb/uart_addr_rx_test.sv
module uart_addr_rx_test;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_CLKS   = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       tick = 1'b0;
   logic       tdiv = 1'b0;
   logic [1:0] mode = 2'd1;
   logic       mpe = 1'b0;
   logic       ren = 1'b1;
   logic [7:0] addr = 8'h3C;
   logic [7:0] mask = 8'hF0;
   logic       fclr = 1'b0;
   logic [7:0] data;
   logic       bit9, flag, gm, bm;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk) begin
      tdiv <= ~tdiv;
      tick <= tdiv;
   end

   uart_addr_rx uut (
      .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick16_i(tick),
      .mode_i(mode), .mpe_i(mpe), .ren_i(ren), .addr_i(addr), .mask_i(mask),
      .flag_clr_i(fclr), .data_o(data), .bit9_o(bit9), .rx_flag_o(flag),
      .given_match_o(gm), .bcast_match_o(bm)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v);
      @(negedge clk) rxd = v;
      repeat (BIT_CLKS - 1) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic nine, input logic stopv);
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(b[i]);
      if (mode != 2'd1) drive_bit(nine);
      drive_bit(stopv);
      @(negedge clk) rxd = 1'b1;
      repeat (2 * BIT_CLKS) @(negedge clk);
   endtask

   task automatic clear_flag();
      @(negedge clk) fclr = 1'b1;
      @(negedge clk) fclr = 1'b0;
   endtask

   function automatic logic exp_given(input logic [7:0] b);
      return ((b ^ addr) & mask) == 8'h00;
   endfunction

   function automatic logic exp_bcast(input logic [7:0] b);
      return (b & (addr | mask)) == (addr | mask);
   endfunction

   task automatic t_reset();
      chk("R1 flag", flag, 0);
      chk("R1 data", data, 0);
      chk("R1 bit9", bit9, 0);
   endtask

   task automatic t_mode1();
      mode = 2'd1; mpe = 1'b0;
      send_frame(8'hA6, 1'b0, 1'b1);
      chk("R2 flag", flag, 1);
      chk("R2 data", data, 8'hA6);
      chk("R2 stop as bit9", bit9, 1);
      clear_flag();
      chk("R6 clear", flag, 0);
   endtask

   task automatic t_nine_plain();
      mode = 2'd3; mpe = 1'b0;
      send_frame(8'h5A, 1'b0, 1'b1);
      chk("R3 flag", flag, 1);
      chk("R3 data", data, 8'h5A);
      chk("R3 bit9", bit9, 0);
      clear_flag();
      mode = 2'd2;
      send_frame(8'h81, 1'b1, 1'b1);
      chk("R3 data mode2", data, 8'h81);
      chk("R3 bit9 mode2", bit9, 1);
      clear_flag();
   endtask

   task automatic t_glitch();
      mode = 2'd1;
      @(negedge clk) rxd = 1'b0;
      repeat (6) @(negedge clk);
      rxd = 1'b1;
      repeat (3 * BIT_CLKS) @(negedge clk);
      chk("R4 glitch no flag", flag, 0);
      chk("R4 data kept", data, 8'h81);
      send_frame(8'h0F, 1'b0, 1'b1);
      chk("R4 next frame ok", data, 8'h0F);
      clear_flag();
   endtask

   task automatic t_disabled();
      ren = 1'b0;
      send_frame(8'hC3, 1'b0, 1'b1);
      chk("R5 no flag", flag, 0);
      chk("R5 data kept", data, 8'h0F);
      ren = 1'b1;
   endtask

   task automatic t_overrun();
      mode = 2'd1;
      send_frame(8'h11, 1'b0, 1'b1);
      send_frame(8'h22, 1'b0, 1'b1);
      chk("R6 flag sticky", flag, 1);
      chk("R6 old byte kept", data, 8'h11);
      clear_flag();
   endtask

   task automatic t_filter();
      mode = 2'd3; mpe = 1'b1;
      send_frame(8'h37, 1'b1, 1'b1);
      chk("R9 given addr loads", flag, 1);
      chk("R9 data", data, 8'h37);
      chk("R7 given out", gm, exp_given(8'h37));
      chk("R8 bcast out", bm, exp_bcast(8'h37));
      clear_flag();
      send_frame(8'hFE, 1'b1, 1'b1);
      chk("R9 bcast addr loads", flag, 1);
      chk("R8 bcast out", bm, 1);
      chk("R7 given out", gm, exp_given(8'hFE));
      clear_flag();
      send_frame(8'h55, 1'b1, 1'b1);
      chk("R9 miss dropped", flag, 0);
      send_frame(8'h37, 1'b0, 1'b1);
      chk("R9 data frame dropped", flag, 0);
      chk("R9 data kept", data, 8'hFE);
      mode = 2'd1;
      send_frame(8'h55, 1'b0, 1'b1);
      chk("R11 mode1 ignores mpe", flag, 1);
      chk("R11 data", data, 8'h55);
      chk("R7 given low", gm, exp_given(8'h55));
      clear_flag();
      mpe = 1'b0;
   endtask

   task automatic t_mode0();
      mode = 2'd0;
      send_frame(8'h99, 1'b1, 1'b1);
      chk("R10 no flag", flag, 0);
      chk("R10 data kept", data, 8'h55);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_mode1();
      t_nine_plain();
      t_glitch();
      t_disabled();
      t_overrun();
      t_filter();
      t_mode0();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule